// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses the direction of a conditional branch. Two component predictors run side by side. The first is a two-level per-branch predictor: a table of local histories, indexed by low branch-address bits, supplies a pattern that selects a 3-bit counter. The second is a global predictor: a table of 2-bit counters indexed by a shift register of recent branch outcomes. A third table of 2-bit chooser counters, indexed the same way as the global table, selects which of the two component guesses becomes the final prediction.

A lookup is purely combinational. The caller presents the low address bits and receives, in the same cycle, the final prediction, both component predictions and the global history that was used. The caller keeps these as a snapshot. When the branch resolves, the caller returns the address, the real outcome and the snapshot on the update port. A separate restore port reloads the global history after a misprediction.

Top module: `tourney_pred`

## Requirements
- R1: After reset, every lookup predicts not-taken. Both component predictions are 0, the chooser selects the local component, and lk_ghist reads 0. Local counters reset to 3, global counters to 1, chooser counters to 1, and all histories to 0.
- R2: lk_taken equals lk_global when the chooser counter at index lk_ghist is 2 or more. Otherwise it equals lk_local. It is valid in the same cycle as lk_pc.
- R3: The local history entry is selected by lk_pc. That 10-bit history selects a 3-bit counter, and lk_local is 1 when the counter is 4 or more.
- R4: lk_global is 1 when the 2-bit global counter at index lk_ghist is 2 or more.
- R5: Every counter increments on a taken outcome and decrements on a not-taken outcome. It saturates at 0 and at its maximum: 7 for local counters, 3 for global and chooser counters.
- R6: A chooser counter changes only when up_local_pred differs from up_global_pred. It increments when the global component matched up_taken and decrements when the local component matched.
- R7: On an update, the local history entry for up_pc shifts left and takes up_taken into bit 0. The local counter trained is the one selected by that entry's value before the shift.
- R8: On an update, the global history shifts left and takes up_taken into bit 0. When rs_valid is high, the global history loads rs_ghist instead, and this takes priority over any update in the same cycle.
- R9: A lookup in the same cycle as an update to the same entries returns the values from before that update.
- R10: The global counter and the chooser counter trained by an update are the ones at index up_ghist, the snapshot history. The live history is not used for this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | LIDX_W | Low branch-address bits for lookup |
| lk_taken | output | 1 | Final direction prediction |
| lk_local | output | 1 | Local component prediction (snapshot) |
| lk_global | output | 1 | Global component prediction (snapshot) |
| lk_ghist | output | GHIST_W | Global history used by this lookup (snapshot) |
| up_valid | input | 1 | Update strobe |
| up_pc | input | LIDX_W | Low branch-address bits of the resolved branch |
| up_taken | input | 1 | Real outcome |
| up_local_pred | input | 1 | Snapshot local prediction |
| up_global_pred | input | 1 | Snapshot global prediction |
| up_ghist | input | GHIST_W | Snapshot global history |
| rs_valid | input | 1 | Global history restore strobe |
| rs_ghist | input | GHIST_W | History value to restore |

## Verification
The bench drives counters into saturation from both sides. A design that wrapped instead of saturating would flip its prediction after one opposite outcome. It trains the chooser with disagreeing snapshots, then sends agreeing ones. A chooser that trained on agreement would drift toward the global side and change lk_taken. Each lookup is aimed at the same address and history that the concurrent update writes, so a design that forwarded the new value would predict one step early. Restores are issued in the same cycle as updates, which exposes a design that let the shift win over the reload. Updates also carry a snapshot history that differs from the live one, so a design that trained at the live index would train the wrong counters.

// File: rtl/tourney_pred.sv
module tourney_pred #(
  parameter int LIDX_W  = 10,
  parameter int LHIST_W = 10,
  parameter int GHIST_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LIDX_W-1:0]  lk_pc,
  output logic               lk_taken,
  output logic               lk_local,
  output logic               lk_global,
  output logic [GHIST_W-1:0] lk_ghist,
  input  logic               up_valid,
  input  logic [LIDX_W-1:0]  up_pc,
  input  logic               up_taken,
  input  logic               up_local_pred,
  input  logic               up_global_pred,
  input  logic [GHIST_W-1:0] up_ghist,
  input  logic               rs_valid,
  input  logic [GHIST_W-1:0] rs_ghist
);
  localparam int LENT = 1 << LIDX_W;
  localparam int LCNT = 1 << LHIST_W;
  localparam int GENT = 1 << GHIST_W;

  logic [LHIST_W-1:0] lhist_q [LENT];
  logic [2:0]         lctr_q  [LCNT];
  logic [1:0]         gctr_q  [GENT];
  logic [1:0]         chc_q   [GENT];
  logic [GHIST_W-1:0] ghr_q;

  logic [LHIST_W-1:0] lk_lh, up_lh;
  logic [2:0]         lc_cur, lc_nxt;
  logic [1:0]         gc_cur, gc_nxt, ch_cur, ch_nxt;
  logic               ch_train;

  assign lk_lh     = lhist_q[lk_pc];
  assign lk_local  = lctr_q[lk_lh][2];
  assign lk_global = gctr_q[ghr_q][1];
  assign lk_ghist  = ghr_q;
  assign lk_taken  = chc_q[ghr_q][1] ? lk_global : lk_local;

  assign up_lh  = lhist_q[up_pc];
  assign lc_cur = lctr_q[up_lh];
  assign gc_cur = gctr_q[up_ghist];
  assign ch_cur = chc_q[up_ghist];

  assign lc_nxt = up_taken ? ((lc_cur == 3'd7) ? lc_cur : lc_cur + 3'd1)
                           : ((lc_cur == 3'd0) ? lc_cur : lc_cur - 3'd1);
  assign gc_nxt = up_taken ? ((gc_cur == 2'd3) ? gc_cur : gc_cur + 2'd1)
                           : ((gc_cur == 2'd0) ? gc_cur : gc_cur - 2'd1);
  assign ch_train = up_local_pred != up_global_pred;
  assign ch_nxt = (up_global_pred == up_taken)
                    ? ((ch_cur == 2'd3) ? ch_cur : ch_cur + 2'd1)
                    : ((ch_cur == 2'd0) ? ch_cur : ch_cur - 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LENT; i++) lhist_q[i] <= '0;
      for (int i = 0; i < LCNT; i++) lctr_q[i]  <= 3'd3;
      for (int i = 0; i < GENT; i++) begin
        gctr_q[i] <= 2'd1;
        chc_q[i]  <= 2'd1;
      end
    end else if (up_valid) begin
      lctr_q[up_lh]    <= lc_nxt;
      lhist_q[up_pc]   <= {up_lh[LHIST_W-2:0], up_taken};
      gctr_q[up_ghist] <= gc_nxt;
      if (ch_train) chc_q[up_ghist] <= ch_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ghr_q <= '0;
    else if (rs_valid) ghr_q <= rs_ghist;
    else if (up_valid) ghr_q <= {ghr_q[GHIST_W-2:0], up_taken};
  end

  assert_restore_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> lk_ghist == $past(rs_ghist));

  assert_ghist_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !rs_valid) |=> lk_ghist[0] == $past(up_taken));

  assert_lhist_newest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> lhist_q[$past(up_pc)][0] == $past(up_taken));

  assert_chooser_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_local_pred == up_global_pred) |=> chc_q[$past(up_ghist)] == $past(ch_cur));

  assert_global_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && gc_cur == 2'd3) |=> gctr_q[$past(up_ghist)] == 2'd3);

  assert_local_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && lc_cur == 3'd0) |=> lctr_q[$past(up_lh)] == 3'd0);
endmodule

// File: tb/test_tourney_pred.sv
module test_tourney_pred;
  localparam int LW = 10;
  localparam int HW = 10;
  localparam int GW = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic [LW-1:0] lk_pc, up_pc;
  logic lk_taken, lk_local, lk_global;
  logic [GW-1:0] lk_ghist, up_ghist, rs_ghist;
  logic up_valid, up_taken, up_local_pred, up_global_pred, rs_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  tourney_pred #(.LIDX_W(LW), .LHIST_W(HW), .GHIST_W(GW)) i_tourney_pred (
    .clk, .rst_n, .lk_pc, .lk_taken, .lk_local, .lk_global, .lk_ghist,
    .up_valid, .up_pc, .up_taken, .up_local_pred, .up_global_pred, .up_ghist,
    .rs_valid, .rs_ghist);

  logic [HW-1:0] m_lh [1<<LW];
  logic [2:0]    m_lc [1<<HW];
  logic [1:0]    m_gc [1<<GW];
  logic [1:0]    m_ch [1<<GW];
  logic [GW-1:0] m_ghr;

  function automatic bit m_lpred(logic [LW-1:0] pc);
    return m_lc[m_lh[pc]] >= 3'd4;
  endfunction
  function automatic bit m_gpred(logic [GW-1:0] gh);
    return m_gc[gh] >= 2'd2;
  endfunction
  function automatic bit m_final(logic [LW-1:0] pc);
    return (m_ch[m_ghr] >= 2'd2) ? m_gpred(m_ghr) : m_lpred(pc);
  endfunction

  task automatic chk(string sig, string req, string phase, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s (%s): got %0d expected %0d", req, sig, phase, got, exp);
    end
  endtask

  task automatic step(string phase, logic [LW-1:0] lpc, logic uv, logic [LW-1:0] upc,
                      logic ut, logic ul, logic ug, logic [GW-1:0] ugh,
                      logic rv, logic [GW-1:0] rgh);
    logic [HW-1:0] lh;
    @(negedge clk);
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut; up_local_pred = ul;
    up_global_pred = ug; up_ghist = ugh; rs_valid = rv; rs_ghist = rgh;
    #1;
    chk("lk_local",  "R3", phase, int'(lk_local),  int'(m_lpred(lpc)));
    chk("lk_global", "R4", phase, int'(lk_global), int'(m_gpred(m_ghr)));
    chk("lk_taken",  "R2", phase, int'(lk_taken),  int'(m_final(lpc)));
    chk("lk_ghist",  "R8", phase, int'(lk_ghist),  int'(m_ghr));
    @(posedge clk);
    if (uv) begin
      lh = m_lh[upc];
      if (ut) begin
        if (m_lc[lh] != 3'd7) m_lc[lh]++;
        if (m_gc[ugh] != 2'd3) m_gc[ugh]++;
      end else begin
        if (m_lc[lh] != 3'd0) m_lc[lh]--;
        if (m_gc[ugh] != 2'd0) m_gc[ugh]--;
      end
      m_lh[upc] = {lh[HW-2:0], ut};
      if (ul != ug) begin
        if (ug == ut) begin if (m_ch[ugh] != 2'd3) m_ch[ugh]++; end
        else          begin if (m_ch[ugh] != 2'd0) m_ch[ugh]--; end
      end
    end
    if (rv)      m_ghr = rgh;
    else if (uv) m_ghr = {m_ghr[GW-2:0], ut};
  endtask

  task automatic train(string phase, logic [LW-1:0] pc, logic t, logic rv, logic [GW-1:0] rgh);
    step(phase, pc, 1'b1, pc, t, m_lpred(pc), m_gpred(m_ghr), m_ghr, rv, rgh);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    if (!done) begin
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < (1<<LW); i++) m_lh[i] = '0;
    for (int i = 0; i < (1<<HW); i++) m_lc[i] = 3'd3;
    for (int i = 0; i < (1<<GW); i++) begin m_gc[i] = 2'd1; m_ch[i] = 2'd1; end
    m_ghr = '0;
    rst_n = 1'b0; lk_pc = '0; up_valid = 0; up_pc = '0; up_taken = 0;
    up_local_pred = 0; up_global_pred = 0; up_ghist = '0; rs_valid = 0; rs_ghist = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    step("R1", 10'd0,   0, '0, 0, 0, 0, '0, 0, '0);
    step("R1", 10'd777, 0, '0, 0, 0, 0, '0, 0, '0);
    chk("lk_taken", "R1", "reset", int'(lk_taken), 0);

    // R5: saturate a global counter high, then walk it back down (history pinned by restore)
    for (int i = 0; i < 10; i++) train("R5 up", 10'd5, 1'b1, 1'b1, '0);
    for (int i = 0; i < 4; i++)  train("R5 down", 10'd5, 1'b0, 1'b1, '0);
    for (int i = 0; i < 10; i++) train("R5 low", 10'd5, 1'b0, 1'b1, '0);
    train("R5 rise", 10'd5, 1'b1, 1'b1, '0);

    // R6: chooser learns global on disagreement, holds on agreement
    for (int i = 0; i < 3; i++)
      step("R6 learn", 10'd7, 1, 10'd7, 1, 0, 1, 12'h0AB, 1, 12'h0AB);
    for (int i = 0; i < 4; i++)
      step("R6 hold", 10'd7, 1, 10'd7, 0, 0, 0, 12'h0AB, 1, 12'h0AB);
    for (int i = 0; i < 5; i++)
      step("R6 back", 10'd7, 1, 10'd7, 1, 1, 0, 12'h0AB, 1, 12'h0AB);

    // R7: alternating outcomes build a local pattern
    for (int i = 0; i < 40; i++) train("R7", 10'd3, 1'(i % 2), 1'b0, '0);

    // R8: restore together with update
    step("R8", 10'd3, 1, 10'd3, 1, 0, 0, m_ghr, 1, 12'hA5C);
    step("R8", 10'd3, 0, 10'd3, 0, 0, 0, '0, 0, '0);

    // R9 / R10: random traffic, same-cycle same-entry lookups, off-snapshot histories
    for (int c = 0; c < 4000; c++) begin
      logic [LW-1:0] pc, lpc;
      logic t, ul, ug, uv, rv;
      logic [GW-1:0] gh;
      pc = LW'($urandom_range(0, 7) * 37);
      t  = ((c % (int'(pc % 5) + 2)) != 0) ^ ($urandom_range(0, 9) == 0);
      uv = $urandom_range(0, 9) < 8;
      rv = $urandom_range(0, 19) == 0;
      if ($urandom_range(0, 3) == 0) begin
        ul = 1'($urandom); ug = 1'($urandom); gh = GW'($urandom);
      end else begin
        ul = m_lpred(pc); ug = m_gpred(m_ghr); gh = m_ghr;
      end
      lpc = ($urandom_range(0, 1) == 0) ? pc : LW'($urandom_range(0, 7) * 37);
      step((lpc == pc) ? "R9" : "R10", lpc, uv, pc, t, ul, ug, gh, rv, GW'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule